// File: doc/BRIEF.md
# Swizzled Macro-Tile Byte Offset Generator

This block turns a pixel coordinate on a two-dimensional macro-tiled surface into the byte offset of that pixel's element. Each access carries a packed tiling configuration, the surface pitch, the element size, depth and stencil selects and a bank-hash mode bit. Consecutive micro tiles are spread over memory channels and banks. The channel and bank numbers come from XOR hashes of coordinate bits, and those numbers are inserted into the offset just above the group-sized low bits of the linear tile address.

The block is a single-stage pipeline. A coordinate presented with `coord_vld` produces a registered offset one clock later. There is no back-pressure. Any configuration it cannot decode raises an error flag and forces the offset to zero. Only single-sample, single-slice surfaces are handled.

Top module: `tile_swz_addr`

## Requirements
- R1: The channel count comes from `tile_cfg[3:1]`. Code 0 selects 1 channel, 1 selects 2, 2 selects 4 and 3 selects 8. Codes 4 to 7 are illegal.
- R2: The bank count comes from `tile_cfg[5:4]` (0 selects 4 banks, 1 selects 8). The group size comes from `tile_cfg[7:6]` (0 selects 256 bytes, 1 selects 512). Codes 2 and 3 of either field are illegal. `tile_cfg[0]` has no effect.
- R3: The result is flagged as an error in three cases: an illegal configuration code, `elem_sel` = 3, or a depth surface with 1-byte elements (`elem_sel` encodes 0=1 byte, 1=2 bytes, 2=4 bytes). On an error, `cfg_err` is 1 and `byte_off` is 0. On a legal access, `cfg_err` is 0.
- R4: The channel number is 0 with 1 channel and x3^y3 with 2 channels. With 4 channels it is {x3^y4, x4^y3}. With 8 channels it is {x3^y5, x4^x5^y4, x5^y3}, MSB first.
- R5: With 4 banks, bit 0 of the bank number is x3^y[4+c] and bit 1 is x4^y[3+c], where c = log2(channels). When `bank_alt` is set, x5 is also XORed into bit 1.
- R6: With 8 banks, bit 0 of the bank number is x3^y[5+c], bit 1 is x4^y[4+c]^y[5+c] and bit 2 is x5^y[3+c]. When `bank_alt` is set, x6 is also XORed into bit 2.
- R7: On colour surfaces the in-tile index lists these bits from LSB to MSB. For 1-byte elements: x0,x1,x2,y1,y0,y2. For 2-byte elements: x0,x1,x2,y0,y1,y2. For 4-byte elements: x0,x1,y0,x2,y1,y2. The element offset is the index times the element bytes.
- R8: On depth surfaces the index is x0,y0,x1,y1,x2,y2. With 2-byte depth the offset is index×2. With 4-byte depth and `is_stencil` set, the offset is index×1. With 4-byte depth and `is_stencil` clear, it is index×3+64. `is_stencil` has no effect on any other surface kind.
- R9: A macro tile covers (banks) micro tiles across and (channels) micro tiles down, each micro tile being 8×8. The number of macro tiles per row is pitch_bytes/elem_bytes/8/banks, rounded down. The macro tile base is (row×tiles_per_row + column) × banks×channels×64×elem_bytes.
- R10: The linear value is L = base/(channels×banks) + element offset, split at the group size G. The result is (L mod G) + channel×G + bank×G×channels + (L div G)×G×channels×banks.
- R11: `off_vld` follows `coord_vld` one clock later. `byte_off` and `cfg_err` are loaded only on valid cycles and hold otherwise.
- R12: When `rst_n` is low at a clock edge, `off_vld`, `byte_off` and `cfg_err` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_cfg | input | 8 | Packed channel, bank and group codes |
| pitch_bytes | input | PITCH_W (16) | Surface row pitch in bytes |
| elem_sel | input | 2 | Element size code: 0=1B, 1=2B, 2=4B |
| is_depth | input | 1 | Surface is a depth surface |
| is_stencil | input | 1 | Address the stencil part of a 4-byte depth tile |
| bank_alt | input | 1 | Alternate bank hash |
| coord_vld | input | 1 | Coordinate valid |
| coord_x | input | COORD_W (13) | Pixel x |
| coord_y | input | COORD_W (13) | Pixel y |
| off_vld | output | 1 | Offset valid |
| byte_off | output | OFF_W (40) | Byte offset |
| cfg_err | output | 1 | Undecodable configuration |

## Verification
Every offset and error flag is due exactly one rising edge after the coordinate that produced it. The driver applies stimulus just after a falling edge and queues the expected result. The monitor looks at the outputs on the following falling edge, when `off_vld` is high, and compares them with the oldest queued entry, so a result one cycle early or late shows up as a mismatch or an unmatched entry. The hold and reset checks sample on falling edges several cycles after their stimulus, once the outputs have had time to settle.

// File: rtl/tsa_pkg.sv
// Shared types for the swizzled tile address generator.
// Assumes micro tiles of 8x8 elements, a single sample and a single slice.
package tsa_pkg;
    localparam int MICRO_LOG = 3;  // log2 of micro tile edge
    localparam int PIX_LOG   = 6;  // log2 of elements per micro tile

    // Decoded tiling configuration; all sizes kept as log2 values.
    typedef struct packed {
        logic [1:0] chan_log;   // 0..3
        logic [1:0] bank_log;   // 2 or 3
        logic [3:0] grp_log;    // 8 or 9
        logic [1:0] elem_log;   // 0..2
        logic       err;        // undecodable setting
    } tsa_cfg_t;
endpackage

// File: rtl/tsa_cfg_decode.sv
// Decodes the packed tiling word and the element-size code into log2 sizes.
// Assumes bit 0 of the word carries nothing this block needs.
module tsa_cfg_decode
    import tsa_pkg::*;
(
    input  logic [7:0] cfg_word,
    input  logic [1:0] elem_sel,
    input  logic       is_depth,
    output tsa_cfg_t   cfg
);
    logic unused_cfg_bit;
    assign unused_cfg_bit = cfg_word[0];

    // Map each field onto its log2 value and flag illegal codes.
    always_comb begin
        cfg          = '0;
        cfg.chan_log = cfg_word[2:1];
        cfg.bank_log = cfg_word[4] ? 2'd3 : 2'd2;
        cfg.grp_log  = cfg_word[6] ? 4'd9 : 4'd8;
        cfg.elem_log = (elem_sel == 2'd3) ? 2'd0 : elem_sel;
        cfg.err      = cfg_word[3] | cfg_word[5] | cfg_word[7]
                     | (elem_sel == 2'd3)
                     | (is_depth && elem_sel == 2'd0);
    end
endmodule

// File: rtl/tsa_swizzle.sv
// Computes the channel and bank numbers as XOR hashes of coordinate bits.
// Assumes the channel log is 0..3 and the bank log is 2 or 3.
module tsa_swizzle (
    input  logic [6:0] xs,
    input  logic [8:0] ys,
    input  logic [1:0] chan_log,
    input  logic [1:0] bank_log,
    input  logic       alt,
    output logic [2:0] chan,
    output logic [2:0] bank
);
    logic [3:0] i3, i4, i5;

    // y bit positions used by the bank hash move up with the channel count.
    always_comb begin
        i3 = 4'd3 + {2'b00, chan_log};
        i4 = 4'd4 + {2'b00, chan_log};
        i5 = 4'd5 + {2'b00, chan_log};
    end

    // Channel hash for each channel count.
    always_comb begin
        chan = '0;
        case (chan_log)
            2'd1: chan[0] = xs[3] ^ ys[3];
            2'd2: begin
                chan[0] = xs[4] ^ ys[3];
                chan[1] = xs[3] ^ ys[4];
            end
            2'd3: begin
                chan[0] = xs[5] ^ ys[3];
                chan[1] = xs[4] ^ xs[5] ^ ys[4];
                chan[2] = xs[3] ^ ys[5];
            end
            default: chan = '0;
        endcase
    end

    // Bank hash for four or eight banks, with the optional extra x term.
    always_comb begin
        bank = '0;
        if (bank_log == 2'd3) begin
            bank[0] = xs[3] ^ ys[i5];
            bank[1] = xs[4] ^ ys[i4] ^ ys[i5];
            bank[2] = xs[5] ^ ys[i3] ^ (alt & xs[6]);
        end else begin
            bank[0] = xs[3] ^ ys[i4];
            bank[1] = xs[4] ^ ys[i3] ^ (alt & xs[5]);
        end
    end
endmodule

// File: rtl/tsa_elem_offset.sv
// Builds the in-tile pixel index and the byte offset inside one micro tile.
// Assumes the element log is 0..2; the depth-with-1-byte case is flagged elsewhere.
module tsa_elem_offset
    import tsa_pkg::*;
(
    input  logic [2:0] xl,
    input  logic [2:0] yl,
    input  logic [1:0] elem_log,
    input  logic       is_depth,
    input  logic       is_stencil,
    output logic [7:0] elem_off
);
    logic [PIX_LOG-1:0] pix;

    // Interleave the low coordinate bits in the order the surface kind uses.
    always_comb begin
        if (is_depth)
            pix = {yl[2], xl[2], yl[1], xl[1], yl[0], xl[0]};
        else begin
            case (elem_log)
                2'd0:    pix = {yl[2], yl[0], yl[1], xl[2], xl[1], xl[0]};
                2'd1:    pix = {yl[2], yl[1], yl[0], xl[2], xl[1], xl[0]};
                default: pix = {yl[2], yl[1], xl[2], yl[0], xl[1], xl[0]};
            endcase
        end
    end

    // Scale the index; 4-byte depth puts stencil bytes before 3-byte depth values.
    always_comb begin
        if (is_depth && elem_log == 2'd2)
            elem_off = is_stencil ? {2'b00, pix}
                                  : ({2'b00, pix} + {1'b0, pix, 1'b0}) + 8'd64;
        else
            elem_off = {2'b00, pix} << elem_log;
    end
endmodule

// File: rtl/tile_swz_addr.sv
// Top: converts (x, y) on a macro-tiled surface into a swizzled byte offset,
// registered one clock after the valid input. Assumes one sample, one slice.
module tile_swz_addr
    import tsa_pkg::*;
#(
    parameter int COORD_W = 13,
    parameter int PITCH_W = 16,
    parameter int OFF_W   = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         tile_cfg,
    input  logic [PITCH_W-1:0] pitch_bytes,
    input  logic [1:0]         elem_sel,
    input  logic               is_depth,
    input  logic               is_stencil,
    input  logic               bank_alt,
    input  logic               coord_vld,
    input  logic [COORD_W-1:0] coord_x,
    input  logic [COORD_W-1:0] coord_y,
    output logic               off_vld,
    output logic [OFF_W-1:0]   byte_off,
    output logic               cfg_err
);
    localparam int TILE_W = COORD_W - MICRO_LOG;

    tsa_cfg_t   cfg;
    logic [2:0] chan, bank;
    logic [7:0] elem_off;

    tsa_cfg_decode u_dec (
        .cfg_word (tile_cfg),
        .elem_sel (elem_sel),
        .is_depth (is_depth),
        .cfg      (cfg)
    );

    tsa_swizzle u_swz (
        .xs       (coord_x[6:0]),
        .ys       (coord_y[8:0]),
        .chan_log (cfg.chan_log),
        .bank_log (cfg.bank_log),
        .alt      (bank_alt),
        .chan     (chan),
        .bank     (bank)
    );

    tsa_elem_offset u_eo (
        .xl         (coord_x[2:0]),
        .yl         (coord_y[2:0]),
        .elem_log   (cfg.elem_log),
        .is_depth   (is_depth),
        .is_stencil (is_stencil),
        .elem_off   (elem_off)
    );

    logic [TILE_W-1:0] mt_row, mt_col;
    logic [PITCH_W-1:0] tiles_per_row;
    logic [OFF_W-1:0]  tile_lin, lin, low_part, high_part, grp_mask, comb_off;
    logic [5:0]        sh_bank, sh_high;

    // Locate the macro tile and its index in row-major order.
    always_comb begin
        mt_row        = coord_y[COORD_W-1:MICRO_LOG] >> cfg.chan_log;
        mt_col        = coord_x[COORD_W-1:MICRO_LOG] >> cfg.bank_log;
        tiles_per_row = pitch_bytes >> ({3'd0, cfg.elem_log} + 5'd3 + {3'd0, cfg.bank_log});
        tile_lin      = OFF_W'(mt_row) * OFF_W'(tiles_per_row) + OFF_W'(mt_col);
    end

    // Linear offset with the channel and bank factors already divided out.
    always_comb begin
        lin = (tile_lin << (6 + cfg.elem_log)) + OFF_W'(elem_off);
    end

    // Keep the group-sized low bits and insert channel and bank above them.
    always_comb begin
        grp_mask  = (OFF_W'(1) << cfg.grp_log) - OFF_W'(1);
        low_part  = lin & grp_mask;
        high_part = lin >> cfg.grp_log;
        sh_bank   = {2'b00, cfg.grp_log} + {4'd0, cfg.chan_log};
        sh_high   = sh_bank + {4'd0, cfg.bank_log};
        comb_off  = (high_part << sh_high)
                  | (OFF_W'(bank) << sh_bank)
                  | (OFF_W'(chan) << cfg.grp_log)
                  | low_part;
    end

    // Output register: valid every cycle, data only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_vld  <= 1'b0;
            byte_off <= '0;
            cfg_err  <= 1'b0;
        end else begin
            off_vld <= coord_vld;
            if (coord_vld) begin
                cfg_err  <= cfg.err;
                byte_off <= cfg.err ? '0 : comb_off;
            end
        end
    end
endmodule

// File: rtl/tsa_checker.sv
// Protocol and layout properties of tile_swz_addr, attached by bind.
module tsa_checker #(
    parameter int COORD_W = 13,
    parameter int OFF_W   = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         tile_cfg,
    input logic [1:0]         elem_sel,
    input logic               is_depth,
    input logic               is_stencil,
    input logic               coord_vld,
    input logic               off_vld,
    input logic [OFF_W-1:0]   byte_off,
    input logic               cfg_err
);
    logic cfg_ok;
    assign cfg_ok = !tile_cfg[3] && !tile_cfg[5] && !tile_cfg[7];

    // R11: valid follows the input one clock later.
    p_vld_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        coord_vld |=> off_vld);
    p_vld_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !coord_vld |=> (!off_vld && $stable(byte_off) && $stable(cfg_err)));
    // R12: reset clears the output valid.
    p_reset_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (!off_vld && byte_off == '0 && !cfg_err));
    // R3: illegal codes raise the flag and zero the offset.
    p_err_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (coord_vld && (!cfg_ok || elem_sel == 2'd3)) |=> (cfg_err && byte_off == '0));
    // R8: 4-byte depth values sit above the 64-byte stencil region.
    p_depth_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (coord_vld && cfg_ok && is_depth && elem_sel == 2'd2 && !is_stencil)
        |=> (byte_off[7:0] >= 8'd64));
    p_stencil_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (coord_vld && cfg_ok && is_depth && elem_sel == 2'd2 && is_stencil)
        |=> (byte_off[7:6] == 2'b00));
endmodule

bind tile_swz_addr tsa_checker #(.COORD_W(COORD_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tile_cfg   (tile_cfg),
    .elem_sel   (elem_sel),
    .is_depth   (is_depth),
    .is_stencil (is_stencil),
    .coord_vld  (coord_vld),
    .off_vld    (off_vld),
    .byte_off   (byte_off),
    .cfg_err    (cfg_err)
);

// File: tb/tb_tile_swz_addr.sv
// Scoreboard bench: driver queues expected results, monitor compares on falling edges.
module tb_tile_swz_addr;
    localparam int COORD_W = 13;
    localparam int PITCH_W = 16;
    localparam int OFF_W   = 40;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [7:0]         tile_cfg = '0;
    logic [PITCH_W-1:0] pitch_bytes = '0;
    logic [1:0]         elem_sel = '0;
    logic               is_depth = 1'b0, is_stencil = 1'b0, bank_alt = 1'b0;
    logic               coord_vld = 1'b0;
    logic [COORD_W-1:0] coord_x = '0, coord_y = '0;
    logic               off_vld;
    logic [OFF_W-1:0]   byte_off;
    logic               cfg_err;

    always #10 clk = ~clk;  // 50 MHz

    tile_swz_addr #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W)) dut (
        .clk(clk), .rst_n(rst_n), .tile_cfg(tile_cfg), .pitch_bytes(pitch_bytes),
        .elem_sel(elem_sel), .is_depth(is_depth), .is_stencil(is_stencil),
        .bank_alt(bank_alt), .coord_vld(coord_vld), .coord_x(coord_x),
        .coord_y(coord_y), .off_vld(off_vld), .byte_off(byte_off), .cfg_err(cfg_err)
    );

    typedef struct {
        longint off;
        bit     err;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0, n_fail = 0;
    longint last_off = 0;
    bit     last_err = 0;

    function automatic int bitof(int v, int i);
        return (v >> i) & 1;
    endfunction

    // Behavioural model written directly from the requirement text.
    function automatic void model(input int cfgw, input int pitch, input int es,
                                  input bit dep, input bit stn, input bit alt,
                                  input int x, input int y,
                                  output longint off, output bit err);
        int chc, bkc, gpc, nch, nbk, gbytes, eb, cbits, bbits, gbits, ch, bk, pn, eoff;
        longint tpr, mtb, mto, tot, lo, hi;
        chc = (cfgw >> 1) & 7; bkc = (cfgw >> 4) & 3; gpc = (cfgw >> 6) & 3;
        err = (chc > 3) || (bkc > 1) || (gpc > 1) || (es == 3) || (dep && es == 0);  // R1 R2 R3
        off = 0;
        if (err) return;
        nch = 1 << chc; nbk = bkc ? 8 : 4; gbytes = gpc ? 512 : 256;
        eb = 1 << es; cbits = chc; bbits = bkc ? 3 : 2; gbits = gpc ? 9 : 8;
        ch = 0;  // R4
        if (nch == 2) ch = bitof(x,3) ^ bitof(y,3);
        if (nch == 4) ch = (bitof(x,4) ^ bitof(y,3)) | ((bitof(x,3) ^ bitof(y,4)) << 1);
        if (nch == 8) ch = (bitof(x,5) ^ bitof(y,3)) | ((bitof(x,4) ^ bitof(x,5) ^ bitof(y,4)) << 1)
                         | ((bitof(x,3) ^ bitof(y,5)) << 2);
        if (nbk == 4) begin  // R5
            bk = (bitof(x,3) ^ bitof(y,4+cbits))
               | ((bitof(x,4) ^ bitof(y,3+cbits) ^ (alt ? bitof(x,5) : 0)) << 1);
        end else begin       // R6
            bk = (bitof(x,3) ^ bitof(y,5+cbits))
               | ((bitof(x,4) ^ bitof(y,4+cbits) ^ bitof(y,5+cbits)) << 1)
               | ((bitof(x,5) ^ bitof(y,3+cbits) ^ (alt ? bitof(x,6) : 0)) << 2);
        end
        if (dep) begin       // R8
            pn = bitof(x,0) | bitof(y,0)<<1 | bitof(x,1)<<2 | bitof(y,1)<<3 | bitof(x,2)<<4 | bitof(y,2)<<5;
            if (eb == 2) eoff = pn * 2;
            else eoff = stn ? pn : pn * 3 + 64;
        end else begin       // R7
            if (eb == 1) pn = bitof(x,0) | bitof(x,1)<<1 | bitof(x,2)<<2 | bitof(y,1)<<3 | bitof(y,0)<<4 | bitof(y,2)<<5;
            else if (eb == 2) pn = bitof(x,0) | bitof(x,1)<<1 | bitof(x,2)<<2 | bitof(y,0)<<3 | bitof(y,1)<<4 | bitof(y,2)<<5;
            else pn = bitof(x,0) | bitof(x,1)<<1 | bitof(y,0)<<2 | bitof(x,2)<<3 | bitof(y,1)<<4 | bitof(y,2)<<5;
            eoff = pn * eb;
        end
        tpr = longint'((pitch / eb / 8) / nbk);          // R9
        mtb = longint'(nbk * nch * 64 * eb);
        mto = (longint'((y / 8) / nch) * tpr + longint'((x / 8) / nbk)) * mtb;
        tot = (mto >> (cbits + bbits)) + eoff;          // R10
        lo  = tot & longint'(gbytes - 1);
        hi  = (tot & ~longint'(gbytes - 1)) << (cbits + bbits);
        off = (longint'(bk) << (gbits + cbits)) + (longint'(ch) << gbits) + lo + hi;
        off = off & ((longint'(1) << OFF_W) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: apply one coordinate and queue its expected result.
    task automatic drive(input int cfgw, input int pitch, input int es, input bit dep,
                         input bit stn, input bit alt, input int x, input int y, input string tag);
        exp_t e;
        model(cfgw, pitch, es, dep, stn, alt, x, y, e.off, e.err);
        e.tag = tag;
        sb.push_back(e);
        last_off = e.off; last_err = e.err;
        tile_cfg = 8'(cfgw); pitch_bytes = PITCH_W'(pitch); elem_sel = 2'(es);
        is_depth = dep; is_stencil = stn; bank_alt = alt;
        coord_x = COORD_W'(x); coord_y = COORD_W'(y); coord_vld = 1'b1;
        @(negedge clk);
    endtask

    // Monitor: results are due one rising edge after the driving falling edge.
    always @(negedge clk) begin
        if (rst_n && off_vld) begin
            if (sb.size() == 0) chk(1'b0, "R11 unexpected valid", 1, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                chk(byte_off == OFF_W'(e.off), e.tag, longint'(byte_off), e.off);
                chk(cfg_err == e.err, {e.tag, " R3 flag"}, longint'(cfg_err), longint'(e.err));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state.
        chk(off_vld == 1'b0 && byte_off == '0 && cfg_err == 1'b0, "R12 reset state",
            longint'(byte_off), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: origin and a tile-boundary pixel (R9, R10).
        drive(8'h00, 256, 2, 0, 0, 0, 0, 0, "R10 origin");
        drive(8'h52, 1024, 2, 0, 0, 0, 8, 8, "R9 boundary");
        drive(8'h17, 64, 0, 0, 1, 1, 63, 63, "R8 stencil ignored on colour");

        // Sweep every legal configuration, bank mode and surface kind (R1 R2 R4 R5 R6 R7 R8).
        for (int ch = 0; ch < 4; ch++)
            for (int bk = 0; bk < 2; bk++)
                for (int gp = 0; gp < 2; gp++)
                    for (int alt = 0; alt < 2; alt++)
                        for (int kind = 0; kind < 6; kind++)
                            for (int n = 0; n < 16; n++) begin
                                int cfgw, es, x, y, pitch;
                                bit dep, stn;
                                cfgw = (gp << 6) | (bk << 4) | (ch << 1) | int'($urandom_range(0, 1));
                                dep = (kind >= 3);
                                stn = (kind == 5) || (kind == 0 && n[0]);
                                es = (kind < 3) ? kind : (kind == 3 ? 1 : 2);
                                x = int'($urandom_range(0, 8191));
                                y = int'($urandom_range(0, 8191));
                                pitch = int'($urandom_range(0, 65535));
                                drive(cfgw, pitch, es, dep, stn, alt[0], x, y,
                                      dep ? "R8 depth layout" : "R4 R5 R6 R7 colour");
                            end

        // Illegal codes (R3).
        drive(8'h08, 4096, 2, 0, 0, 0, 100, 200, "R3 channel code 4");
        drive(8'h0E, 4096, 2, 0, 0, 0, 100, 200, "R3 channel code 7");
        drive(8'h20, 4096, 2, 0, 0, 0, 100, 200, "R3 bank code 2");
        drive(8'h30, 4096, 2, 0, 0, 0, 100, 200, "R3 bank code 3");
        drive(8'h80, 4096, 2, 0, 0, 0, 100, 200, "R3 group code 2");
        drive(8'hC0, 4096, 2, 0, 0, 0, 100, 200, "R3 group code 3");
        drive(8'h00, 4096, 3, 0, 0, 0, 100, 200, "R3 element code 3");
        drive(8'h00, 4096, 0, 1, 0, 0, 100, 200, "R3 one-byte depth");
        drive(8'h42, 4096, 1, 0, 0, 0, 77, 91, "R3 legal after error");

        // R11: idle inputs change, outputs hold.
        coord_vld = 1'b0;
        coord_x = 13'd1234; coord_y = 13'd4321; tile_cfg = 8'hFF;
        repeat (3) @(negedge clk);
        chk(off_vld == 1'b0, "R11 idle valid", longint'(off_vld), 0);
        chk(byte_off == OFF_W'(last_off), "R11 idle hold offset", longint'(byte_off), last_off);
        chk(cfg_err == last_err, "R11 idle hold flag", longint'(cfg_err), longint'(last_err));
        chk(sb.size() == 0, "R11 all results delivered", sb.size(), 0);

        // R12: reset during activity clears outputs.
        drive(8'h12, 8192, 2, 0, 0, 0, 500, 700, "R12 pre-reset");
        coord_vld = 1'b0;
        rst_n = 1'b0;
        sb.delete();
        repeat (2) @(negedge clk);
        chk(off_vld == 1'b0 && byte_off == '0 && cfg_err == 1'b0, "R12 mid-run reset",
            longint'(byte_off), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule